// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block gathers characters from sixteen asynchronous receive lines into one shared first-in first-out store, the silo. Each line hands over a character that has already been deserialized, along with parity and framing error flags. The silo records every character as a 16-bit word that carries the character, the number of the line it came from, its error flags and a valid marker. Software drains the silo by reading one register address again and again until the valid marker comes back clear.

Each line has a one-deep holding slot that feeds the silo. When several lines deliver in the same cycle, the slots drain one per cycle, lowest line number first. If a line delivers a second character while its first is still waiting, the second one is lost, and the waiting character goes into the silo with an overrun mark. A control/status register holds a line selector, two interrupt enables, two sticky flags and a self-clearing master clear. The selector picks which line's parameter word is visible at the parameter address. The receive interrupt announces that the silo has stopped being empty. The storage interrupt announces that the fill level has reached a programmable alarm level.

Top module: `tagged_rx_silo`

## Requirements
- R1: After reset the silo is empty, the control/status register reads 0x0000, a receive read returns 0x0000, the alarm register reads 16, every line parameter word is 0 and both interrupt outputs are low.
- R2: A read at address 1 returns the word at the head of the silo and removes it at that clock edge. The word is laid out as follows: bit 15 = 1 (valid), bits 11:8 = line number, bits 7:0 = character. When the silo is empty the read returns 0x0000 and removes nothing.
- R3: A character delivered with its parity error input high is stored with bit 12 set. One delivered with its framing error input high is stored with bit 13 set.
- R4: Characters from one line leave the silo in the order they arrived. Characters that reach their holding slots in the same cycle enter the silo lowest line number first, one per cycle.
- R5: A character that arrives while the same line's previous character is still waiting (the silo being full) is discarded. The waiting character, the next stored entry for that line, carries bit 14 set. Other lines are unaffected.
- R6: Control/status bit 7 (receive flag) sets when the silo count goes from zero to non-zero. Writing the register with bit 7 = 0 clears the flag. The output irq_rx equals the flag ANDed with enable bit 6.
- R7: Control/status bit 14 (storage flag) sets in any cycle where the next fill level is at or above a non-zero alarm level. Writing the register with bit 14 = 0 clears the flag. The output irq_sto equals the flag ANDed with enable bit 12.
- R8: Control/status bits 3:0 select a line. Address 2 reads and writes that line's parameter word, and bits 3 and 15 always read 0. The parameter fields are: bits 1:0 length (1 = 6, 2 = 7, 3 = 8 bits), bit 2 two stop bits, bit 4 parity enable, bit 5 odd parity, bits 9:6 receive speed, bits 13:10 transmit speed, bit 14 half duplex. Line n's word appears on line_params[16n+15:16n].
- R9: Writing control/status with bit 11 set empties the silo and the holding slots, drops pending overrun marks, and clears the flags, enables and selector. It ignores the other bits of that write and leaves parameter words and the alarm level unchanged. Bit 11 always reads 0.
- R10: The silo holds 64 entries. With 64 stored, a waiting character stays in its holding slot until a read makes room.
- R11: Address 3 holds the 7-bit alarm level. Address 0 is control/status. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 control/status, 1 receive, 2 parameter, 3 alarm) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops the silo at address 1 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rx_valid | input | 16 | One strobe per line: a character is delivered this cycle |
| rx_char | input | 128 | Characters, line n in bits 8n+7:8n |
| rx_perr | input | 16 | Per-line parity error for the delivered character |
| rx_ferr | input | 16 | Per-line framing error (break) for the delivered character |
| line_params | output | 256 | Parameter words of all lines, line n in bits 16n+15:16n |
| irq_rx | output | 1 | Receive interrupt request |
| irq_sto | output | 1 | Storage (alarm) interrupt request |

## Verification
The hardest state to reach from the ports is a full silo with one line holding a waiting character and a further character for that line arriving. Only that sequence produces the overrun mark, and it then lets the waiting entry in as soon as one read frees space. The stimulus streams 66 characters into one line on consecutive cycles with the alarm set to the full depth, adds a character on a second line, and then drains all 66 entries back to back. A behavioural queue model in the bench tracks each holding slot and the silo on every cycle, so the bench can compare the overrun-marked entry and its position behind the 64 stored characters exactly.

// File: rtl/tagged_rx_silo_pkg.sv
`timescale 1ns/1ps
package tagged_rx_silo_pkg;

    localparam int LINE_W     = 4;
    localparam int NUM_LINES  = 1 << LINE_W;
    localparam int CHAR_W     = 8;
    localparam int REG_W      = 16;
    localparam int REG_ADDR_W = 2;

    // control/status bit positions
    localparam int CSR_RX_EN    = 6;
    localparam int CSR_RX_FLAG  = 7;
    localparam int CSR_MCLR     = 11;
    localparam int CSR_STO_EN   = 12;
    localparam int CSR_STO_FLAG = 14;

    localparam logic [REG_W-1:0] PARAM_MASK = 16'h7FF7;
    localparam int ALARM_RESET = 16;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CSR    = 2'd0,
        REG_RXCHAR = 2'd1,
        REG_LPARAM = 2'd2,
        REG_ALARM  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } silo_word_t;

    function automatic silo_word_t make_word(input logic ovr, input logic ferr,
                                             input logic perr,
                                             input logic [LINE_W-1:0] line,
                                             input logic [CHAR_W-1:0] ch);
        silo_word_t w;
        w.valid = 1'b1;
        w.ovr   = ovr;
        w.ferr  = ferr;
        w.perr  = perr;
        w.line  = line;
        w.ch    = ch;
        return w;
    endfunction

endpackage

// File: rtl/tagged_rx_silo_capture.sv
`timescale 1ns/1ps
// One-deep holding slot per line with overrun tracking.
module tagged_rx_silo_capture
    import tagged_rx_silo_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic [NUM_LINES-1:0]          rx_valid,
    input  logic [NUM_LINES*CHAR_W-1:0]   rx_char,
    input  logic [NUM_LINES-1:0]          rx_perr,
    input  logic [NUM_LINES-1:0]          rx_ferr,
    input  logic [NUM_LINES-1:0]          grant,
    output logic [NUM_LINES-1:0]          slot_valid,
    output silo_word_t [NUM_LINES-1:0]    slot_word
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic              held_q;
        logic              ovr_q;
        logic              perr_q;
        logic              ferr_q;
        logic [CHAR_W-1:0] ch_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                held_q <= 1'b0;
                ovr_q  <= 1'b0;
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
                ch_q   <= '0;
            end else if (rx_valid[i]) begin
                if (held_q && !grant[i]) begin
                    // slot still occupied: new character lost
                    ovr_q <= 1'b1;
                end else begin
                    held_q <= 1'b1;
                    ovr_q  <= 1'b0;
                    ch_q   <= rx_char[i*CHAR_W +: CHAR_W];
                    perr_q <= rx_perr[i];
                    ferr_q <= rx_ferr[i];
                end
            end else if (grant[i]) begin
                held_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
        end

        assign slot_valid[i] = held_q;
        assign slot_word[i]  = make_word(ovr_q, ferr_q, perr_q, LINE_W'(i), ch_q);
    end

endmodule

// File: rtl/tagged_rx_silo_arb.sv
`timescale 1ns/1ps
// Lowest-line-first selection of one waiting slot per cycle.
module tagged_rx_silo_arb
    import tagged_rx_silo_pkg::*;
(
    input  logic                       allow,
    input  logic [NUM_LINES-1:0]       req,
    input  silo_word_t [NUM_LINES-1:0] words,
    output logic [NUM_LINES-1:0]       grant,
    output logic                       push,
    output silo_word_t                 push_word
);

    always_comb begin
        grant     = '0;
        push      = 1'b0;
        push_word = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (allow && req[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                push      = 1'b1;
                push_word = words[i];
            end
        end
    end

endmodule

// File: rtl/tagged_rx_silo_fifo.sv
`timescale 1ns/1ps
// Shared silo storage.
module tagged_rx_silo_fifo
    import tagged_rx_silo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       push,
    input  silo_word_t                 push_word,
    input  logic                       pop,
    output silo_word_t                 head_word,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [$clog2(DEPTH+1)-1:0] count_next,
    output logic                       full,
    output logic                       empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    silo_word_t      mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            push_ok;
    logic            pop_ok;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full       = (count == CW'(DEPTH));
    assign empty      = (count == '0);
    assign push_ok    = push && !full;
    assign pop_ok     = pop && !empty;
    assign count_next = count + CW'(push_ok) - CW'(pop_ok);
    assign head_word  = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= advance(wr_ptr);
            if (pop_ok)  rd_ptr <= advance(rd_ptr);
            count <= count_next;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clear) mem[wr_ptr] <= push_word;
    end

endmodule

// File: rtl/tagged_rx_silo.sv
`timescale 1ns/1ps
module tagged_rx_silo
    import tagged_rx_silo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [REG_ADDR_W-1:0]       bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]        rx_valid,
    input  logic [NUM_LINES*CHAR_W-1:0] rx_char,
    input  logic [NUM_LINES-1:0]        rx_perr,
    input  logic [NUM_LINES-1:0]        rx_ferr,
    output logic [NUM_LINES*REG_W-1:0]  line_params,
    output logic                        irq_rx,
    output logic                        irq_sto
);

    localparam int CW = $clog2(DEPTH + 1);

    reg_sel_e                  addr_e;
    logic                      csr_wr;
    logic                      mclr;
    logic                      pop;
    logic [LINE_W-1:0]         line_sel;
    logic                      rx_en_q, sto_en_q;
    logic                      rx_flag_q, sto_flag_q;
    logic [CW-1:0]             alarm_q;
    logic [REG_W-1:0]          param_q [NUM_LINES];

    logic [NUM_LINES-1:0]      slot_valid;
    silo_word_t [NUM_LINES-1:0] slot_word;
    logic [NUM_LINES-1:0]      grant;
    logic                      push;
    silo_word_t                push_word;
    silo_word_t                head_word;
    logic [CW-1:0]             silo_count;
    logic [CW-1:0]             count_next;
    logic                      full;
    logic                      empty;
    logic                      rx_set, sto_set;
    logic [REG_W-1:0]          csr_word;

    assign addr_e = reg_sel_e'(bus_addr);
    assign csr_wr = bus_wr && (addr_e == REG_CSR);
    assign mclr   = csr_wr && bus_wdata[CSR_MCLR];
    assign pop    = bus_rd && (addr_e == REG_RXCHAR);

    tagged_rx_silo_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .clear      (mclr),
        .rx_valid   (rx_valid),
        .rx_char    (rx_char),
        .rx_perr    (rx_perr),
        .rx_ferr    (rx_ferr),
        .grant      (grant),
        .slot_valid (slot_valid),
        .slot_word  (slot_word)
    );

    tagged_rx_silo_arb u_arb (
        .allow     (!full && !mclr),
        .req       (slot_valid),
        .words     (slot_word),
        .grant     (grant),
        .push      (push),
        .push_word (push_word)
    );

    tagged_rx_silo_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .clear      (mclr),
        .push       (push),
        .push_word  (push_word),
        .pop        (pop),
        .head_word  (head_word),
        .count      (silo_count),
        .count_next (count_next),
        .full       (full),
        .empty      (empty)
    );

    assign rx_set  = (silo_count == '0) && (count_next != '0);
    assign sto_set = (alarm_q != '0) && (count_next >= alarm_q);

    // control/status
    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            line_sel   <= '0;
            rx_en_q    <= 1'b0;
            sto_en_q   <= 1'b0;
            rx_flag_q  <= 1'b0;
            sto_flag_q <= 1'b0;
        end else begin
            if (csr_wr) begin
                line_sel <= bus_wdata[LINE_W-1:0];
                rx_en_q  <= bus_wdata[CSR_RX_EN];
                sto_en_q <= bus_wdata[CSR_STO_EN];
            end
            if (rx_set)
                rx_flag_q <= 1'b1;
            else if (csr_wr && !bus_wdata[CSR_RX_FLAG])
                rx_flag_q <= 1'b0;
            if (sto_set)
                sto_flag_q <= 1'b1;
            else if (csr_wr && !bus_wdata[CSR_STO_FLAG])
                sto_flag_q <= 1'b0;
        end
    end

    // alarm level and per-line parameters
    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= CW'(ALARM_RESET);
            for (int i = 0; i < NUM_LINES; i++) param_q[i] <= '0;
        end else if (bus_wr) begin
            if (addr_e == REG_ALARM)
                alarm_q <= bus_wdata[CW-1:0];
            if (addr_e == REG_LPARAM)
                param_q[line_sel] <= bus_wdata & PARAM_MASK;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_param_out
        assign line_params[i*REG_W +: REG_W] = param_q[i];
    end

    always_comb begin
        csr_word               = '0;
        csr_word[LINE_W-1:0]   = line_sel;
        csr_word[CSR_RX_EN]    = rx_en_q;
        csr_word[CSR_RX_FLAG]  = rx_flag_q;
        csr_word[CSR_STO_EN]   = sto_en_q;
        csr_word[CSR_STO_FLAG] = sto_flag_q;
    end

    always_comb begin
        unique case (addr_e)
            REG_CSR:    bus_rdata = csr_word;
            REG_RXCHAR: bus_rdata = empty ? '0 : REG_W'(head_word);
            REG_LPARAM: bus_rdata = param_q[line_sel];
            REG_ALARM:  bus_rdata = REG_W'(alarm_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_rx  = rx_flag_q && rx_en_q;
    assign irq_sto = sto_flag_q && sto_en_q;

endmodule

// File: rtl/tagged_rx_silo_chk.sv
`timescale 1ns/1ps
module tagged_rx_silo_chk #(
    parameter int DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 bus_addr,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [15:0]                bus_wdata,
    input logic [15:0]                bus_rdata,
    input logic                       irq_rx,
    input logic                       irq_sto,
    input logic [$clog2(DEPTH+1)-1:0] silo_count,
    input logic [$clog2(DEPTH+1)-1:0] alarm_q,
    input logic                       rx_flag_q,
    input logic                       sto_flag_q
);

    // R10
    silo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        silo_count <= ($clog2(DEPTH+1))'(DEPTH));

    // R2
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1 && silo_count == '0) |-> (bus_rdata == 16'h0000));

    // R2
    valid_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1 && silo_count != '0) |-> bus_rdata[15]);

    // R6
    rx_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (silo_count == '0 ##1 silo_count != '0) |-> rx_flag_q);

    // R7
    sto_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(bus_wr) && alarm_q != '0 && silo_count >= alarm_q) |-> sto_flag_q);

    // R9
    mclr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[11]) |=> (silo_count == '0 && !irq_rx && !irq_sto));

endmodule

bind tagged_rx_silo tagged_rx_silo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_rx     (irq_rx),
    .irq_sto    (irq_sto),
    .silo_count (silo_count),
    .alarm_q    (alarm_q),
    .rx_flag_q  (rx_flag_q),
    .sto_flag_q (sto_flag_q)
);

// File: tb/tagged_rx_silo_bench.sv
`timescale 1ns/1ps
module tagged_rx_silo_bench;

    localparam int NL    = 16;
    localparam int DEPTH = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic [NL-1:0]   rx_valid = '0;
    logic [NL*8-1:0] rx_char = '0;
    logic [NL-1:0]   rx_perr = '0;
    logic [NL-1:0]   rx_ferr = '0;
    logic [NL*16-1:0] line_params;
    logic            irq_rx;
    logic            irq_sto;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tagged_rx_silo #(.DEPTH(DEPTH)) u_tagged_rx_silo (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .line_params(line_params), .irq_rx(irq_rx), .irq_sto(irq_sto)
    );

    // ---------------- reference model ----------------
    logic [15:0] mq[$];
    bit          hv[NL];
    bit          ov[NL];
    bit          hp[NL];
    bit          hf[NL];
    logic [7:0]  hc[NL];
    bit          m_ri, m_sto, m_rien, m_stoen;
    logic [3:0]  m_sel;
    logic [15:0] m_par[NL];
    int          m_alarm;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            for (int l = 0; l < NL; l++) begin
                hv[l] = 0; ov[l] = 0; hp[l] = 0; hf[l] = 0; hc[l] = '0; m_par[l] = '0;
            end
            m_ri = 0; m_sto = 0; m_rien = 0; m_stoen = 0; m_sel = '0; m_alarm = 16;
        end else if (bus_wr && bus_addr == 2'd0 && bus_wdata[11]) begin
            mq.delete();
            for (int l = 0; l < NL; l++) begin hv[l] = 0; ov[l] = 0; end
            m_ri = 0; m_sto = 0; m_rien = 0; m_stoen = 0; m_sel = '0;
        end else begin
            int  cnt, ncnt, g;
            bit  popn;
            cnt  = mq.size();
            popn = bus_rd && bus_addr == 2'd1 && cnt > 0;
            g = -1;
            if (cnt < DEPTH)
                for (int l = NL - 1; l >= 0; l--) if (hv[l]) g = l;
            ncnt = cnt + (g >= 0 ? 1 : 0) - (popn ? 1 : 0);
            if (popn) void'(mq.pop_front());
            if (g >= 0) mq.push_back({1'b1, ov[g], hf[g], hp[g], 4'(g), hc[g]});
            for (int l = 0; l < NL; l++) begin
                bit drained;
                drained = (l == g);
                if (rx_valid[l]) begin
                    if (hv[l] && !drained) ov[l] = 1;
                    else begin
                        hv[l] = 1; ov[l] = 0; hc[l] = rx_char[l*8 +: 8];
                        hp[l] = rx_perr[l]; hf[l] = rx_ferr[l];
                    end
                end else if (drained) begin
                    hv[l] = 0; ov[l] = 0;
                end
            end
            if (bus_wr && bus_addr == 2'd0) begin
                m_rien = bus_wdata[6]; m_stoen = bus_wdata[12]; m_sel = bus_wdata[3:0];
                if (!bus_wdata[7])  m_ri = 0;
                if (!bus_wdata[14]) m_sto = 0;
            end
            if (cnt == 0 && ncnt != 0) m_ri = 1;
            if (m_alarm != 0 && ncnt >= m_alarm) m_sto = 1;
            if (bus_wr && bus_addr == 2'd2) m_par[m_sel] = bus_wdata & 16'h7FF7;
            if (bus_wr && bus_addr == 2'd3) m_alarm = int'(bus_wdata[6:0]);
        end
    end

    function automatic logic [15:0] model_rdata();
        logic [15:0] w;
        w = '0;
        case (bus_addr)
            2'd0: begin
                w[14] = m_sto; w[12] = m_stoen; w[7] = m_ri; w[6] = m_rien; w[3:0] = m_sel;
            end
            2'd1: w = (mq.size() > 0) ? mq[0] : 16'h0000;
            2'd2: w = m_par[m_sel];
            default: w = 16'(m_alarm);
        endcase
        return w;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            string t;
            case (bus_addr)
                2'd0: t = "R6 csr";
                2'd1: t = "R2 rxchar";
                2'd2: t = "R8 param";
                default: t = "R11 alarm";
            endcase
            check(bus_rdata, model_rdata(), t);
            check(irq_rx, m_ri && m_rien, "R6 irq_rx");
            check(irq_sto, m_sto && m_stoen, "R7 irq_sto");
            for (int l = 0; l < NL; l++)
                check(line_params[l*16 +: 16], m_par[l], "R8 line_params");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; rx_valid = '0; rx_perr = '0; rx_ferr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        step();
        bus_addr = a; bus_wdata = d; bus_wr = 1;
    endtask

    task automatic read_expect(input logic [1:0] a, input logic [15:0] exp, input string tag);
        step();
        bus_addr = a; bus_rd = 1;
        #1;
        check(bus_rdata, exp, tag);
    endtask

    task automatic strobe(input int line, input logic [7:0] ch, input bit p, input bit f);
        step();
        rx_valid[line] = 1; rx_char[line*8 +: 8] = ch; rx_perr[line] = p; rx_ferr[line] = f;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst = 0;

        // R1 reset state
        read_expect(2'd0, 16'h0000, "R1 csr reset");
        read_expect(2'd1, 16'h0000, "R1 empty silo");
        read_expect(2'd3, 16'd16,   "R1 alarm reset");
        read_expect(2'd2, 16'h0000, "R1 param reset");
        #1; check(irq_rx, 0, "R1 irq_rx"); check(irq_sto, 0, "R1 irq_sto");

        // R2 / R3 tagging and error bits
        strobe(5, 8'h41, 1, 0);
        idle(2);
        read_expect(2'd1, 16'h9541, "R3 parity tag");
        read_expect(2'd1, 16'h0000, "R2 empty after pop");
        strobe(9, 8'h00, 0, 1);
        idle(2);
        read_expect(2'd1, 16'hA900, "R3 framing tag");
        write_reg(2'd1, 16'hFFFF);
        read_expect(2'd1, 16'h0000, "R11 write to rx ignored");

        // R4 simultaneous arrivals, lowest line first
        step();
        rx_valid[7] = 1; rx_char[7*8 +: 8] = 8'h70;
        rx_valid[2] = 1; rx_char[2*8 +: 8] = 8'h20;
        rx_valid[12] = 1; rx_char[12*8 +: 8] = 8'hC0;
        idle(4);
        read_expect(2'd1, 16'h8220, "R4 first line2");
        read_expect(2'd1, 16'h8770, "R4 then line7");
        read_expect(2'd1, 16'h8CC0, "R4 then line12");
        read_expect(2'd1, 16'h0000, "R2 drained");

        // R6 receive flag and interrupt
        write_reg(2'd0, 16'h0040);
        step(); #1; check(irq_rx, 0, "R6 flag cleared");
        strobe(1, 8'h31, 0, 0);
        idle(3); #1; check(irq_rx, 1, "R6 irq on non-empty");
        read_expect(2'd1, 16'h8131, "R2 line1 char");
        write_reg(2'd0, 16'h0040);
        step(); #1; check(irq_rx, 0, "R6 cleared by write");

        // R10 / R5 / R7 full silo with overrun
        write_reg(2'd3, 16'd64);
        write_reg(2'd0, 16'h1040);
        for (int i = 0; i < 66; i++) begin
            step();
            rx_valid[3] = 1; rx_char[3*8 +: 8] = 8'(i);
        end
        strobe(4, 8'h44, 0, 0);
        idle(3); #1;
        check(irq_sto, 1, "R7 alarm reached at 64");
        for (int i = 0; i < 64; i++)
            read_expect(2'd1, 16'h8300 | 16'(i), "R10 stored order");
        read_expect(2'd1, 16'hC340, "R5 overrun on waiting entry");
        read_expect(2'd1, 16'h8444, "R5 other line unaffected");
        read_expect(2'd1, 16'h0000, "R5 dropped char absent");
        write_reg(2'd0, 16'h1040);
        step(); #1; check(irq_sto, 0, "R7 flag cleared");

        // R8 parameters
        write_reg(2'd0, 16'h1046);
        write_reg(2'd2, 16'hFFFF);
        read_expect(2'd2, 16'h7FF7, "R8 masked param");
        #1; check(line_params[6*16 +: 16], 16'h7FF7, "R8 line6 out");
        write_reg(2'd0, 16'h1042);
        read_expect(2'd2, 16'h0000, "R8 other line");
        write_reg(2'd2, 16'h0C53);
        read_expect(2'd2, 16'h0C53, "R8 line2 write");

        // R9 master clear
        step();
        for (int l = 0; l < 4; l++) begin rx_valid[l] = 1; rx_char[l*8 +: 8] = 8'(8'h50 + l); end
        idle(2);
        write_reg(2'd0, 16'h1FC6);
        read_expect(2'd0, 16'h0000, "R9 csr cleared");
        read_expect(2'd1, 16'h0000, "R9 silo emptied");
        idle(3);
        read_expect(2'd1, 16'h0000, "R9 slots emptied");
        #1; check(irq_rx, 0, "R9 irq_rx low"); check(irq_sto, 0, "R9 irq_sto low");
        read_expect(2'd3, 16'd64, "R9 alarm kept");
        write_reg(2'd0, 16'h0006);
        read_expect(2'd2, 16'h7FF7, "R9 params kept");

        idle(2);
        finish_run();
    end

endmodule